// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block sits on the controller side of a two-bank single-data-rate SDRAM. It runs the start-up sequence the memory needs before any normal traffic is allowed. From reset it holds the clock-enable and data-mask pins high and sends only no-operation commands through a long settling pause. It then closes both banks with one precharge-all command. Next it loads the mode register and issues a burst of auto-refresh commands. The order of those last two steps is chosen by a parameter.

Every minimum interval is given as a time in picoseconds together with the clock period. Each interval becomes a cycle count: the time divided by the period, rounded up, and never less than one. Between commands the sequencer sends no-operation commands until the interval of the last command has run out. When the final interval ends, a sticky ready flag rises. Normal read, write and refresh scheduling are handled elsewhere. All command pins are registered. There is no data path, so the block has no handshake; every pin is a plain level.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the command pins carry a NOP. A NOP is chip-select low with row strobe, column strobe and write enable high, i.e. {cs_n,ras_n,cas_n,we_n}=4'b0111. In that state the address is zero, mem_cke and mem_dqm are 1, and init_done is 0.
- R2: mem_cke and mem_dqm stay 1 on every cycle. After reset is released, the first PAUSE_C clock edges produce only NOPs.
- R3: At clock edge number PAUSE_C after reset release, a precharge-all is issued for one cycle. Its encoding is {cs_n,ras_n,cas_n,we_n}=4'b0010 with address bit AP_BIT (bit 10) set and all other address bits zero.
- R4: The mode-register load is issued exactly once, for one cycle. Its encoding is 4'b0000 with the address equal to MODE_OP.
- R5: Exactly max(NUM_REF,8) auto-refresh commands are issued, each for one cycle. The encoding is 4'b0001 with the address zero.
- R6: When MODE_FIRST=1 the mode-register load follows the precharge by RP_C edges, and the refreshes follow it. When MODE_FIRST=0 the refreshes follow the precharge by RP_C edges, and the mode-register load follows the last refresh by RC_C edges.
- R7: The next command comes exactly one interval after the one before it, with only NOPs in between. The interval is RP_C after the precharge, RC_C after a refresh and MRD_C after the mode-register load.
- R8: init_done rises at edge PAUSE_C+RP_C+MRD_C+NREF*RC_C after reset release. It then stays 1 until reset, and only NOPs are issued while it is 1.
- R9: Asserting reset in the middle of the sequence returns the block to the R1 state. Releasing reset restarts the whole sequence from the pause.
- R10: Each cycle count is ceil(time_ps / CLK_PS), with a minimum of 1. PAUSE_C, RP_C, RC_C and MRD_C are derived this way from T_PAUSE_PS, T_RP_PS, T_RC_PS and T_MRD_PS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cke | output | 1 | Clock enable, held high |
| mem_dqm | output | 1 | Data mask, held high |
| mem_addr | output | ADDR_W | Address bus: precharge-all flag or mode opcode |
| init_done | output | 1 | Sticky flag that start-up is finished |

## Verification
The bound checker watches every cycle for the following:
- only the four legal command encodings appear on the pins;
- mem_cke and mem_dqm never drop;
- a precharge always carries the all-banks bit, and a mode load always carries MODE_OP;
- the refresh count never goes past its target;
- no command arrives before the interval of the one before it has run out;
- the ready flag never falls, and it comes with NOPs only.

Other properties need the bench's scenarios. These are the exact edge of each command, the order selected by MODE_FIRST, the total refresh count, the rounding of picosecond times into cycles, and a clean restart after a reset in mid-sequence. The bench shows them by sweeping every cycle of two differently parameterised instances and comparing each against a schedule it computes itself.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_MRS = 2'd2,
    CMD_REF = 2'd3
  } boot_cmd_e;

  typedef enum logic [2:0] {
    PH_PAUSE = 3'd0,
    PH_PRE   = 3'd1,
    PH_MRS   = 3'd2,
    PH_REF   = 3'd3,
    PH_DONE  = 3'd4
  } boot_phase_e;

  // Minimum cycle count: time over period, rounded up, at least one.
  function automatic int unsigned cyc_of(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             expired
);

  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RST_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= RST_CNT;
    end else if (load) begin
      cnt_q <= load_len - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_boot_pins.sv
module sdram_boot_pins
  import sdram_boot_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 12,
  parameter int unsigned       AP_BIT  = 10,
  parameter logic [ADDR_W-1:0] MODE_OP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  boot_cmd_e         cmd,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  logic [3:0]        pins_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    unique case (cmd)
      CMD_PRE: begin pins_d = 4'b0010; addr_d = AP_MASK; end
      CMD_MRS: begin pins_d = 4'b0000; addr_d = MODE_OP; end
      CMD_REF: begin pins_d = 4'b0001; addr_d = '0;      end
      default: begin pins_d = 4'b0111; addr_d = '0;      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
      addr                       <= '0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= pins_d;
      addr                       <= addr_d;
    end
  end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int unsigned       CLK_PS      = 10000,
  parameter int unsigned       T_PAUSE_PS  = 200000000,
  parameter int unsigned       T_RP_PS     = 20000,
  parameter int unsigned       T_RC_PS     = 70000,
  parameter int unsigned       T_MRD_PS    = 20000,
  parameter int unsigned       NUM_REF     = 8,
  parameter bit                MODE_FIRST  = 1'b1,
  parameter int unsigned       ADDR_W      = 12,
  parameter int unsigned       AP_BIT      = 10,
  parameter logic [ADDR_W-1:0] MODE_OP     = 12'h022
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_cke,
  output logic              mem_dqm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  localparam int unsigned PAUSE_C = cyc_of(T_PAUSE_PS, CLK_PS);
  localparam int unsigned RP_C    = cyc_of(T_RP_PS, CLK_PS);
  localparam int unsigned RC_C    = cyc_of(T_RC_PS, CLK_PS);
  localparam int unsigned MRD_C   = cyc_of(T_MRD_PS, CLK_PS);
  localparam int unsigned REF_N   = (NUM_REF < 8) ? 8 : NUM_REF;
  localparam int unsigned MAX_C   = max2(max2(PAUSE_C, RP_C), max2(RC_C, MRD_C));
  localparam int unsigned CNT_W   = $clog2(MAX_C + 1);
  localparam int unsigned REF_W   = $clog2(REF_N + 1);

  boot_phase_e      phase_q, phase_d;
  logic [REF_W-1:0] ref_left_q, ref_left_d;
  logic             done_q, done_d;
  boot_cmd_e        cmd;
  logic             t_load;
  logic [CNT_W-1:0] t_len;
  logic             t_expired;

  // Step order chosen at elaboration.
  boot_cmd_e after_pre;
  logic      mrs_is_last;
  generate
    if (MODE_FIRST) begin : g_mode_first
      assign after_pre   = CMD_MRS;
      assign mrs_is_last = 1'b0;
    end else begin : g_ref_first
      assign after_pre   = CMD_REF;
      assign mrs_is_last = 1'b1;
    end
  endgenerate

  sdram_boot_timer #(
    .CNT_W  (CNT_W),
    .RST_LEN(PAUSE_C)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .load_len(t_len),
    .expired (t_expired)
  );

  always_comb begin
    cmd        = CMD_NOP;
    phase_d    = phase_q;
    ref_left_d = ref_left_q;
    done_d     = done_q;

    if (t_expired && !done_q) begin
      unique case (phase_q)
        PH_PAUSE: cmd = CMD_PRE;
        PH_PRE:   cmd = after_pre;
        PH_MRS: begin
          if (mrs_is_last) done_d = 1'b1;
          else             cmd    = CMD_REF;
        end
        PH_REF: begin
          if (ref_left_q != '0) cmd    = CMD_REF;
          else if (mrs_is_last) cmd    = CMD_MRS;
          else                  done_d = 1'b1;
        end
        default: ;
      endcase
    end

    unique case (cmd)
      CMD_PRE: phase_d = PH_PRE;
      CMD_MRS: phase_d = PH_MRS;
      CMD_REF: begin
        phase_d    = PH_REF;
        ref_left_d = ref_left_q - REF_W'(1);
      end
      default: if (done_d) phase_d = PH_DONE;
    endcase
  end

  always_comb begin
    t_load = (cmd != CMD_NOP);
    unique case (cmd)
      CMD_PRE: t_len = CNT_W'(RP_C);
      CMD_MRS: t_len = CNT_W'(MRD_C);
      CMD_REF: t_len = CNT_W'(RC_C);
      default: t_len = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_PAUSE;
      ref_left_q <= REF_W'(REF_N);
      done_q     <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      ref_left_q <= ref_left_d;
      done_q     <= done_d;
    end
  end

  sdram_boot_pins #(
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT),
    .MODE_OP(MODE_OP)
  ) u_pins (
    .clk  (clk),
    .rst_n(rst_n),
    .cmd  (cmd),
    .cs_n (mem_cs_n),
    .ras_n(mem_ras_n),
    .cas_n(mem_cas_n),
    .we_n (mem_we_n),
    .addr (mem_addr)
  );

  assign mem_cke   = 1'b1;
  assign mem_dqm   = 1'b1;
  assign init_done = done_q;

endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk #(
  parameter int unsigned       ADDR_W  = 12,
  parameter int unsigned       AP_BIT  = 10,
  parameter logic [ADDR_W-1:0] MODE_OP = '0,
  parameter int unsigned       REF_N   = 8,
  parameter int unsigned       RP_C    = 1,
  parameter int unsigned       RC_C    = 1,
  parameter int unsigned       MRD_C   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              cke,
  input logic              dqm,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  logic [3:0] pins;
  logic is_nop, is_pre, is_mrs, is_ref, is_cmd;
  int   since_q, need_q, refs_q;
  logic have_q;

  assign pins   = {cs_n, ras_n, cas_n, we_n};
  assign is_nop = (pins == 4'b0111);
  assign is_pre = (pins == 4'b0010);
  assign is_mrs = (pins == 4'b0000);
  assign is_ref = (pins == 4'b0001);
  assign is_cmd = is_pre || is_mrs || is_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= 0;
      need_q  <= 0;
      refs_q  <= 0;
      have_q  <= 1'b0;
    end else if (is_cmd) begin
      have_q  <= 1'b1;
      since_q <= 1;
      need_q  <= is_pre ? int'(RP_C) : (is_mrs ? int'(MRD_C) : int'(RC_C));
      if (is_ref) refs_q <= refs_q + 1;
    end else if (since_q < 32'h3fff_ffff) begin
      since_q <= since_q + 1;
    end
  end

  // R1
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop || is_cmd);

  // R2
  cke_dqm_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke && dqm);

  // R3
  pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> addr[AP_BIT]);

  // R4
  mode_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (addr == MODE_OP));

  // R5
  ref_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (refs_q < int'(REF_N)));

  // R7
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && have_q) |-> (since_q >= need_q));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);

endmodule

bind sdram_boot_seq sdram_boot_chk #(
  .ADDR_W (ADDR_W),
  .AP_BIT (AP_BIT),
  .MODE_OP(MODE_OP),
  .REF_N  (REF_N),
  .RP_C   (RP_C),
  .RC_C   (RC_C),
  .MRD_C  (MRD_C)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (mem_cs_n),
  .ras_n    (mem_ras_n),
  .cas_n    (mem_cas_n),
  .we_n     (mem_we_n),
  .cke      (mem_cke),
  .dqm      (mem_dqm),
  .addr     (mem_addr),
  .init_done(init_done)
);

// File: tb/sdram_boot_seq_tb.sv
`timescale 1ns/1ps
module sdram_boot_seq_tb;

  localparam int CLK_PS = 10000;
  localparam int SWEEP  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_done;
  logic b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done;
  logic [11:0] a_addr, b_addr;

  sdram_boot_seq #(
    .CLK_PS(CLK_PS), .T_PAUSE_PS(95000), .T_RP_PS(20000), .T_RC_PS(65000),
    .T_MRD_PS(15000), .NUM_REF(8), .MODE_FIRST(1'b1), .MODE_OP(12'h022)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_cs_n(a_cs), .mem_ras_n(a_ras),
    .mem_cas_n(a_cas), .mem_we_n(a_we), .mem_cke(a_cke), .mem_dqm(a_dqm),
    .mem_addr(a_addr), .init_done(a_done)
  );

  sdram_boot_seq #(
    .CLK_PS(CLK_PS), .T_PAUSE_PS(50000), .T_RP_PS(25000), .T_RC_PS(30000),
    .T_MRD_PS(10000), .NUM_REF(9), .MODE_FIRST(1'b0), .MODE_OP(12'h031)
  ) u_dut_b (
    .clk(clk), .rst_n(rst_n), .mem_cs_n(b_cs), .mem_ras_n(b_ras),
    .mem_cas_n(b_cas), .mem_we_n(b_we), .mem_cke(b_cke), .mem_dqm(b_dqm),
    .mem_addr(b_addr), .init_done(b_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int W[2], P[2], C[2], M[2], N[2];
  bit MF[2];
  logic [11:0] OP[2];
  int first_mrs[2], first_ref[2], nref[2], done_at[2];

  // R10: rounding up of picosecond times
  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int exp_cmd(input int id, input int t);
    int r0, mt;
    if (t == W[id]) return 1;
    r0 = MF[id] ? W[id] + P[id] + M[id] : W[id] + P[id];
    mt = MF[id] ? W[id] + P[id] : W[id] + P[id] + N[id] * C[id];
    if (t == mt) return 2;
    if (t >= r0 && t < r0 + N[id] * C[id] && ((t - r0) % C[id]) == 0) return 3;
    return 0;
  endfunction

  function automatic int dec(input logic [3:0] p);
    case (p)
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0000: return 2;
      4'b0001: return 3;
      default: return 9;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input int id, input string req);
    logic [3:0] p;
    logic [11:0] ad;
    logic ck, dq, dn;
    if (id == 0) begin p = {a_cs,a_ras,a_cas,a_we}; ad = a_addr; ck = a_cke; dq = a_dqm; dn = a_done; end
    else         begin p = {b_cs,b_ras,b_cas,b_we}; ad = b_addr; ck = b_cke; dq = b_dqm; dn = b_done; end
    chk(p == 4'b0111 && ad == 12'h000 && ck && dq && !dn, req,
        {16'h0, ck, dq, dn, 1'b0, p, ad}, {16'h0, 4'b1100, 4'b0111, 12'h000});
  endtask

  task automatic chk_cycle(input int id, input int t);
    logic [3:0] p;
    logic [11:0] ad, ea;
    logic ck, dq, dn;
    int e, a, dt;
    string rq;
    if (id == 0) begin p = {a_cs,a_ras,a_cas,a_we}; ad = a_addr; ck = a_cke; dq = a_dqm; dn = a_done; end
    else         begin p = {b_cs,b_ras,b_cas,b_we}; ad = b_addr; ck = b_cke; dq = b_dqm; dn = b_done; end
    e = exp_cmd(id, t);
    a = dec(p);
    case (e)
      1: rq = "R3";
      2: rq = "R4";
      3: rq = "R5";
      default: rq = (t < W[id]) ? "R2" : "R7";
    endcase
    chk(a == e, rq, a, e);
    ea = (e == 1) ? 12'h400 : ((e == 2) ? OP[id] : 12'h000);
    chk(ad == ea, rq, int'(ad), int'(ea));
    chk(ck && dq, "R2", {ck, dq}, 2'b11);
    dt = W[id] + P[id] + M[id] + N[id] * C[id];
    chk(dn == (t >= dt), "R8", dn, (t >= dt));
    if (a == 2 && first_mrs[id] < 0) first_mrs[id] = t;
    if (a == 3 && first_ref[id] < 0) first_ref[id] = t;
    if (a == 3) nref[id]++;
    if (dn && done_at[id] < 0) done_at[id] = t;
  endtask

  task automatic sweep(input bool_full);
    for (int id = 0; id < 2; id++) begin
      first_mrs[id] = -1; first_ref[id] = -1; nref[id] = 0; done_at[id] = -1;
    end
    for (int t = 1; t <= SWEEP; t++) begin
      @(posedge clk);
      @(negedge clk);
      for (int id = 0; id < 2; id++) chk_cycle(id, t);
    end
    for (int id = 0; id < 2; id++) begin
      chk(nref[id] == N[id], "R5", nref[id], N[id]);
      if (MF[id]) begin
        chk(first_mrs[id] == W[id] + P[id] && first_ref[id] == first_mrs[id] + M[id],
            "R6", first_ref[id], W[id] + P[id] + M[id]);
      end else begin
        chk(first_ref[id] == W[id] + P[id] && first_mrs[id] == first_ref[id] + N[id] * C[id],
            "R6", first_mrs[id], W[id] + P[id] + N[id] * C[id]);
      end
      chk(done_at[id] == W[id] + P[id] + M[id] + N[id] * C[id], "R10",
          done_at[id], W[id] + P[id] + M[id] + N[id] * C[id]);
    end
  endtask

  initial begin
    W[0] = cyc(95000); P[0] = cyc(20000); C[0] = cyc(65000); M[0] = cyc(15000);
    N[0] = 8; MF[0] = 1'b1; OP[0] = 12'h022;
    W[1] = cyc(50000); P[1] = cyc(25000); C[1] = cyc(30000); M[1] = cyc(10000);
    N[1] = 9; MF[1] = 1'b0; OP[1] = 12'h031;

    repeat (3) @(negedge clk);
    chk_idle(0, "R1");
    chk_idle(1, "R1");
    rst_n = 1'b1;
    sweep(1'b1);

    // R9: reset in the middle of the sequence
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk_idle(0, "R9");
    chk_idle(1, "R9");
    rst_n = 1'b1;
    repeat (25) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle(0, "R9");
    chk_idle(1, "R9");
    rst_n = 1'b1;
    sweep(1'b1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule